// File: doc/BRIEF.md
# Format Track Write Pulse Thinner

This block produces the write pulses, write gate and erase gate for laying down a format track. Format data and the filler that follows it are clocked from a fast 400 ns cell tick. That rate is too high for the channel that later reads the format track back. To bring the pulse rate down, the block drops every even bit position and the last bit position of each character. It keeps the last bit position of a character that comes right before a gap, so the gap timers downstream still see a closing pulse.

Once the data and a fixed run of fast-timed filler characters have been written, the block switches its timing to a slower phase tick. It switches only on a character boundary. From then on it writes every bit of the filler pattern unthinned. When the index area ends, it drops the write and erase gates together. The erase head trails the write head, so a strip of filler is left unerased and can be used for head alignment.

Upstream logic supplies one character at a time and replaces it after each character-taken pulse. The character width (6 or 8 cells) is fixed when a track starts.

Top module: `fmt_write_thinner`

## Requirements
- R1: After reset, `write_gate`, `erase_gate`, `wr_pulse`, `done` and `char_take` are all low.
- R2: A `start` pulse while idle does four things at the next clock edge: it raises both gates, latches the presented character, clears the bit position to 0, and gives a one-cycle `char_take` pulse. Each further data character latched also gives one `char_take` pulse. A `start` while a track is in progress is ignored.
- R3: While the fast cell tick is the source, even bit positions (0, 2, 4, 6) never produce a write pulse.
- R4: In fast timing, the last position of a character (7 in 8-bit mode, 5 in 6-bit mode) produces a pulse only if `char_gap` was high when that character was latched and its bit there is 1.
- R5: In fast timing, any other odd position whose character bit is 1 produces a one-cycle `wr_pulse` in the cycle after the tick. Bit n of `char_bits` belongs to position n, counted from 0.
- R6: `eight_bit` is sampled at `start`: 1 gives 8-cell characters, 0 gives 6-cell characters (bits 0 to 5). Changing it during a track has no effect.
- R7: After the character latched with `char_last` has been written, exactly 11 filler characters (pattern `fill_bits`) are written from the fast tick, thinned as in R3 to R5, with no gap marker.
- R8: After those 11 characters, `phase_tick` becomes the source and every bit of `fill_bits` set to 1 gives a pulse. A tick from the source that is not selected does nothing: it neither writes nor advances the position.
- R9: The timing source changes only at a character boundary. The first slow-timed cell is position 0.
- R10: `index_end` during the slow filler drops both gates at the same clock edge. At any other time it is ignored.
- R11: `done` pulses high for one cycle, in the cycle after the gates fall.
- R12: In fast timing, two consecutive source ticks never both produce a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a format track |
| eight_bit | input | 1 | Character width select: 1 = 8 cells, 0 = 6 cells |
| cell_tick | input | 1 | Fast 400 ns bit-cell tick |
| phase_tick | input | 1 | Slow phase-source bit tick |
| char_bits | input | 8 | Presented data character, bit n = position n |
| char_gap | input | 1 | Presented character is followed by a gap |
| char_last | input | 1 | Presented character is the last data character |
| fill_bits | input | 8 | Filler character pattern |
| index_end | input | 1 | End of index area; releases the gates |
| char_take | output | 1 | Presented character has been latched |
| wr_pulse | output | 1 | Write pulse, one cycle per written bit |
| write_gate | output | 1 | Write gate |
| erase_gate | output | 1 | Erase gate |
| done | output | 1 | Gates have been released |

## Verification
The bench aims at the ends of each character. It checks the last cell with and without the gap marker in both widths: a design that leaked the last bit would double the pulse rate at character joins, and one that always dropped it would starve the gap timers. It counts the fast filler exactly, using off-source ticks and an early `index_end`. An off-by-one count, a mid-character source switch, or counting a tick from the wrong source shows up as pulses at shifted positions or as gates released too early. It also flips the width select in mid-track and issues a stray `start`; a design that reacted to either would emit pulses in the wrong cells or an extra `char_take`.

// File: rtl/fmt_thin_pkg.sv
package fmt_thin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_FFILL = 3'd2,
    ST_SLOW  = 3'd3,
    ST_DONE  = 3'd4
  } fmt_stage_e;

  localparam int unsigned CHAR_MAX_W = 8;
  localparam int unsigned POS_W      = $clog2(CHAR_MAX_W);
endpackage

// File: rtl/fmt_cell_pos.sv
module fmt_cell_pos
  import fmt_thin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [POS_W-1:0] last_pos,
  output logic [POS_W-1:0] pos,
  output logic             char_end
);
  logic [POS_W-1:0] pos_q, pos_n;

  assign char_end = tick && (pos_q == last_pos);
  assign pos      = pos_q;

  always_comb begin
    pos_n = pos_q;
    if (clear) begin
      pos_n = '0;
    end else if (tick) begin
      if (pos_q == last_pos) pos_n = '0;
      else                   pos_n = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_n;
  end

  // R9: position never passes the configured last cell
  a_r9_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= last_pos || $changed(last_pos) || $past(clear));
endmodule

// File: rtl/fmt_pulse_gate.sv
module fmt_pulse_gate
  import fmt_thin_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  fast,
  input  logic [POS_W-1:0]      pos,
  input  logic [POS_W-1:0]      last_pos,
  input  logic [CHAR_MAX_W-1:0] bits,
  input  logic                  gap,
  output logic                  wr_pulse
);
  logic written, thin_ok;
  logic wr_q, wr_n;
  logic prev_q, prev_n;

  always_comb begin
    thin_ok = pos[0] && ((pos != last_pos) || gap);
    written = bits[pos] && (!fast || thin_ok);
    wr_n    = tick && written;
    prev_n  = prev_q;
    if (!fast)     prev_n = 1'b0;
    else if (tick) prev_n = written;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      prev_q <= prev_n;
    end
  end

  assign wr_pulse = wr_q;

  a_r3_even_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && !pos[0]) |=> !wr_pulse);
  a_r12_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && prev_q) |=> !wr_pulse);
  a_r4_last_needs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && pos == last_pos && !gap) |=> !wr_pulse);
endmodule

// File: rtl/fmt_stage_ctl.sv
module fmt_stage_ctl
  import fmt_thin_pkg::*;
#(
  parameter int unsigned FAST_FILL_CHARS = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  eight_bit,
  input  logic                  char_end,
  input  logic [CHAR_MAX_W-1:0] char_bits,
  input  logic                  char_gap,
  input  logic                  char_last,
  input  logic [CHAR_MAX_W-1:0] fill_bits,
  input  logic                  index_end,
  output fmt_stage_e            stage,
  output logic [CHAR_MAX_W-1:0] cur_bits,
  output logic                  cur_gap,
  output logic [POS_W-1:0]      last_pos,
  output logic                  write_gate,
  output logic                  erase_gate,
  output logic                  done,
  output logic                  char_take
);
  localparam int unsigned FC_W = $clog2(FAST_FILL_CHARS + 1);
  localparam logic [POS_W-1:0] LAST8 = POS_W'(7);
  localparam logic [POS_W-1:0] LAST6 = POS_W'(5);

  fmt_stage_e            st_q, st_n;
  logic [CHAR_MAX_W-1:0] bits_q, bits_n;
  logic                  gap_q, gap_n, last_q, last_n, m8_q, m8_n;
  logic [FC_W-1:0]       fc_q, fc_n;
  logic                  wg_q, wg_n, eg_q, eg_n, done_q, done_n, take_q, take_n;

  always_comb begin
    st_n   = st_q;
    bits_n = bits_q;
    gap_n  = gap_q;
    last_n = last_q;
    m8_n   = m8_q;
    fc_n   = fc_q;
    wg_n   = wg_q;
    eg_n   = eg_q;
    done_n = 1'b0;
    take_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n   = ST_DATA;
        bits_n = char_bits;
        gap_n  = char_gap;
        last_n = char_last;
        m8_n   = eight_bit;
        fc_n   = '0;
        wg_n   = 1'b1;
        eg_n   = 1'b1;
        take_n = 1'b1;
      end
      ST_DATA: if (char_end) begin
        if (last_q) begin
          st_n   = ST_FFILL;
          bits_n = fill_bits;
          gap_n  = 1'b0;
          last_n = 1'b0;
          fc_n   = '0;
        end else begin
          bits_n = char_bits;
          gap_n  = char_gap;
          last_n = char_last;
          take_n = 1'b1;
        end
      end
      ST_FFILL: if (char_end) begin
        bits_n = fill_bits;
        if (fc_q == FC_W'(FAST_FILL_CHARS - 1)) st_n = ST_SLOW;
        else                                   fc_n = fc_q + 1'b1;
      end
      ST_SLOW: begin
        if (char_end) bits_n = fill_bits;
        if (index_end) begin
          st_n = ST_DONE;
          wg_n = 1'b0;
          eg_n = 1'b0;
        end
      end
      ST_DONE: begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bits_q <= '0;
      gap_q  <= 1'b0;
      last_q <= 1'b0;
      m8_q   <= 1'b1;
      fc_q   <= '0;
      wg_q   <= 1'b0;
      eg_q   <= 1'b0;
      done_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bits_q <= bits_n;
      gap_q  <= gap_n;
      last_q <= last_n;
      m8_q   <= m8_n;
      fc_q   <= fc_n;
      wg_q   <= wg_n;
      eg_q   <= eg_n;
      done_q <= done_n;
      take_q <= take_n;
    end
  end

  assign stage      = st_q;
  assign cur_bits   = bits_q;
  assign cur_gap    = gap_q;
  assign last_pos   = m8_q ? LAST8 : LAST6;
  assign write_gate = wg_q;
  assign erase_gate = eg_q;
  assign done       = done_q;
  assign char_take  = take_q;

  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> (write_gate && erase_gate && char_take));
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FFILL) |-> (fc_q < FC_W'(FAST_FILL_CHARS)));
  a_r10_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_gate) |-> ($past(index_end) && $past(st_q == ST_SLOW) && $fell(erase_gate)));
  a_r11_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!write_gate && !$past(write_gate) && $past(write_gate, 2)));
  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(m8_q));
endmodule

// File: rtl/fmt_write_thinner.sv
module fmt_write_thinner
  import fmt_thin_pkg::*;
#(
  parameter int unsigned FAST_FILL_CHARS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       eight_bit,
  input  logic       cell_tick,
  input  logic       phase_tick,
  input  logic [7:0] char_bits,
  input  logic       char_gap,
  input  logic       char_last,
  input  logic [7:0] fill_bits,
  input  logic       index_end,
  output logic       char_take,
  output logic       wr_pulse,
  output logic       write_gate,
  output logic       erase_gate,
  output logic       done
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  fmt_stage_e            stage;
  logic [CHAR_MAX_W-1:0] cur_bits;
  logic                  cur_gap;
  logic [POS_W-1:0]      last_pos, pos;
  logic                  fast, active, src_tick, tick_en, char_end, pos_clear;

  always_comb begin
    fast      = (stage == ST_DATA) || (stage == ST_FFILL);
    active    = fast || (stage == ST_SLOW);
    src_tick  = fast ? cell_tick : phase_tick;
    tick_en   = active && src_tick;
    pos_clear = (stage == ST_IDLE) && start;
  end

  fmt_stage_ctl #(.FAST_FILL_CHARS(FAST_FILL_CHARS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .eight_bit  (eight_bit),
    .char_end   (char_end),
    .char_bits  (char_bits),
    .char_gap   (char_gap),
    .char_last  (char_last),
    .fill_bits  (fill_bits),
    .index_end  (index_end),
    .stage      (stage),
    .cur_bits   (cur_bits),
    .cur_gap    (cur_gap),
    .last_pos   (last_pos),
    .write_gate (write_gate),
    .erase_gate (erase_gate),
    .done       (done),
    .char_take  (char_take)
  );

  fmt_cell_pos u_pos (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clear    (pos_clear),
    .tick     (tick_en),
    .last_pos (last_pos),
    .pos      (pos),
    .char_end (char_end)
  );

  fmt_pulse_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick_en),
    .fast     (fast),
    .pos      (pos),
    .last_pos (last_pos),
    .bits     (cur_bits),
    .gap      (cur_gap),
    .wr_pulse (wr_pulse)
  );

  a_r8_slow_ignores_cell: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stage == ST_SLOW && !phase_tick) |=> !wr_pulse);
  a_r8_fast_ignores_phase: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fast && !cell_tick) |=> !wr_pulse);
  a_r9_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stage == ST_FFILL) ##1 (stage == ST_SLOW) |-> (pos == '0));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stage == ST_IDLE) |=> !wr_pulse);
endmodule

// File: tb/fmt_write_thinner_tb.sv
module fmt_write_thinner_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, eight_bit, cell_tick, phase_tick, char_gap, char_last, index_end;
  logic [7:0] char_bits, fill_bits;
  logic       char_take, wr_pulse, write_gate, erase_gate, done;

  int checks = 0;
  int errors = 0;
  int takes  = 0;
  int cyc    = 0;
  bit finished = 1'b0;
  bit saw_tick;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  fmt_write_thinner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .eight_bit(eight_bit),
    .cell_tick(cell_tick), .phase_tick(phase_tick), .char_bits(char_bits),
    .char_gap(char_gap), .char_last(char_last), .fill_bits(fill_bits),
    .index_end(index_end), .char_take(char_take), .wr_pulse(wr_pulse),
    .write_gate(write_gate), .erase_gate(erase_gate), .done(done)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: scoreboard pop on the cycle after each tick
  always @(posedge clk) saw_tick <= cell_tick | phase_tick;
  always @(negedge clk) begin
    if (saw_tick) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, wr_pulse, e);
      end
    end
    if (char_take) takes++;
  end

  function automatic bit exp_w(int p, int lastp, logic [7:0] b, bit gap, bit fast_src);
    if (!fast_src) return b[p];
    return b[p] && (p % 2 == 1) && (p != lastp || gap);
  endfunction

  function automatic string tag_of(int p, int lastp, bit fast_src);
    if (!fast_src)     return "R8 slow cell";
    if (p % 2 == 0)    return "R3 even cell";
    if (p == lastp)    return "R4 last cell";
    return "R5 odd cell";
  endfunction

  task automatic tick(bit use_phase, bit e, string t);
    @(negedge clk);
    if (use_phase) phase_tick = 1'b1; else cell_tick = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    phase_tick = 1'b0;
    cell_tick  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_char(logic [7:0] b, bit gap, int w, bit fast_src);
    for (int p = 0; p < w; p++)
      tick(!fast_src, exp_w(p, w - 1, b, gap, fast_src), tag_of(p, w - 1, fast_src));
  endtask

  task automatic present(logic [7:0] b, bit g, bit l);
    char_bits = b; char_gap = g; char_last = l;
  endtask

  task automatic do_start(bit m8);
    @(negedge clk);
    eight_bit = m8;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 write gate up", write_gate, 1);
    check("R2 erase gate up", erase_gate, 1);
    check("R2 char_take pulse", char_take, 1);
  endtask

  task automatic release_gates();
    @(negedge clk);
    index_end = 1'b1;
    @(negedge clk);
    index_end = 1'b0;
    check("R10 write gate down", write_gate, 0);
    check("R10 erase gate down", erase_gate, 0);
    check("R11 done not yet", done, 0);
    @(negedge clk);
    check("R11 done pulse", done, 1);
    @(negedge clk);
    check("R11 done one cycle", done, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; eight_bit = 1; cell_tick = 0; phase_tick = 0;
    char_bits = 0; char_gap = 0; char_last = 0; fill_bits = 8'hB7; index_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 write gate", write_gate, 0);
    check("R1 erase gate", erase_gate, 0);
    check("R1 wr_pulse", wr_pulse, 0);
    check("R1 done", done, 0);
    check("R1 char_take", char_take, 0);

    // ---- track 1: 8-bit characters ----
    present(8'hFF, 0, 0);
    do_start(1);
    present(8'hFF, 1, 0);
    tick(1, 0, "R8 phase tick ignored in fast data");
    run_char(8'hFF, 0, 8, 1);
    present(8'h5A, 0, 1);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; // stray start, R2
    run_char(8'hFF, 1, 8, 1);
    present(8'h00, 0, 0);
    run_char(8'h5A, 0, 8, 1);
    for (int k = 0; k < 11; k++) begin
      run_char(fill_bits, 0, 8, 1);
      if (k == 4) begin
        @(negedge clk); index_end = 1'b1; @(negedge clk); index_end = 1'b0;
        check("R10 early index_end ignored", write_gate, 1);
      end
    end
    run_char(fill_bits, 0, 8, 0);
    tick(0, 0, "R8 cell tick ignored in slow filler");
    run_char(fill_bits, 0, 8, 0);
    for (int p = 0; p < 3; p++)
      tick(1, fill_bits[p], "R9 slow partial char");
    check("R7 gates held through filler", write_gate & erase_gate, 1);
    release_gates();
    check("R2 char_take count track1", takes, 3);

    // ---- track 2: 6-bit characters, width select flipped mid-track ----
    takes = 0;
    fill_bits = 8'h2F;
    present(8'hFF, 1, 0);
    do_start(0);
    eight_bit = 1'b1;
    present(8'h2A, 0, 1);
    run_char(8'hFF, 1, 6, 1);
    run_char(8'h2A, 0, 6, 1);
    for (int k = 0; k < 11; k++) run_char(fill_bits, 0, 6, 1);
    run_char(fill_bits, 0, 6, 0);
    tick(1, fill_bits[0], "R9 first slow cell is position 0");
    release_gates();
    check("R6 char_take count track2", takes, 2);
    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule